// File: doc/BRIEF.md
# Serial IO Shift Clock Generator and Frame Run Control

This block produces the shift clock and the end-of-frame strobe for a serial general purpose IO link that runs from a 75 MHz reference clock. In internal mode the shift clock comes from a programmable divider. Each half period lasts `clk_div * 8 + 1` reference cycles, which gives 75 MHz / (2 * (clk_div * 8 + 1)). A 15-bit divide value reaches down to about 143 Hz. Any value that would push the clock above the 200 kHz limit raises a flag.

A run bit gates the frames. After reset the link stays idle until the run bit is set. Frames then follow each other until the bit is cleared. A frame that is already under way when the bit clears still runs to its end, including its end strobe, before the link goes idle.

Each frame shifts a programmed number of bits. The datapath receives a pulse on every falling shift-clock edge, when it advances its outgoing bit. It receives a qualified pulse on every rising edge, when it takes in an incoming bit. The first incoming bit of each frame is discarded. The clock and end pins can be driven push-pull or open-drain. An external-clock mode turns the clock pin into an input and bypasses the divider.

Top module: `sio_clkgen`

## Requirements
- R1: In internal mode, every high and every low phase of the shift clock lasts `clk_div*8+1` reference cycles. The clock rests low while no frame is active.
- R2: `too_fast` is 1 exactly when internal mode is selected and `clk_div` is below 24. It is 0 in external-clock mode.
- R3: After reset, and for as long as `run_en` is 0, the shift clock rests low, the end strobe stays low and no edge pulse is produced.
- R4: While `run_en` stays 1, frames repeat back to back. Each frame gives exactly L `shift_edge` pulses, one per falling edge. The end strobe then stays high for exactly one shift-clock period (two half periods).
- R5: If `run_en` is cleared while a frame is in progress, that frame still completes with its full end strobe. After that the shift clock stops and no further frame starts.
- R6: `sample_valid` pulses on rising edges inside a frame, except the first rising edge of each frame. This gives L-1 pulses per frame.
- R7: The effective length L is `frame_len`, with two exceptions. When `bidir_mode` is 1, a value below 2 becomes 2. When `bidir_mode` is 0, a value of 0 becomes 1.
- R8: When `od_mode` is 1, `sclk_o` and `send_o` are 0, and each output enable is 1 only while its line level is low. When `od_mode` is 0, the enables are 1 and the outputs carry the line levels.
- R9: When `ext_clk_mode` is 1, `sclk_oe` is 0 and the divider is unused. Edges come from the synchronized `sclk_i`. A frame starts only at a falling edge of `sclk_i`, and the end strobe lasts one `sclk_i` period.
- R10: `shift_edge` and `sample_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Frame run enable |
| clk_div | input | 15 | Divide value; half period = clk_div*8+1 cycles |
| frame_len | input | 8 | Bits per frame |
| bidir_mode | input | 1 | Transfer mode that needs at least 2 bits per frame |
| od_mode | input | 1 | 1 = open-drain pins, 0 = push-pull |
| ext_clk_mode | input | 1 | 1 = shift clock taken from sclk_i |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Shift clock pin output value |
| sclk_oe | output | 1 | Shift clock pin output enable |
| send_o | output | 1 | End strobe pin output value |
| send_oe | output | 1 | End strobe pin output enable |
| shift_edge | output | 1 | Falling-edge pulse: advance outgoing bit |
| sample_valid | output | 1 | Rising-edge pulse: take incoming bit |
| too_fast | output | 1 | Divide value exceeds the 200 kHz limit |

## Verification
The assertions assume that `clk_div`, `frame_len` and the mode inputs are changed only while the link is idle. They also assume that `sclk_i` is a clean clock whose phases are much longer than the synchronizer depth. The bench follows both rules. It changes settings only after the end strobe has fallen and the run bit is low. It drives the external clock with a fixed ten-cycle period on the falling reference edge. The bench checks frame contents against a queue of expected frame shapes that the stimulus task computes from the length and divide settings.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_END   = 2'd2
   } sio_state_e;

   localparam int unsigned SIO_SCALE_SH = 3;
   localparam int unsigned SIO_PIN_CNT  = 2;

endpackage

// File: rtl/sio_div.sv
module sio_div #(
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned SCALE_SH    = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ext_mode,
   input  logic [DIV_W-1:0] div_val,
   input  logic             ext_clk_i,
   output logic             clk_lvl,
   output logic             rise_p,
   output logic             fall_p
);

   localparam int unsigned CNT_W = DIV_W + SCALE_SH;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_div: SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("sio_div: DIV_W must be at least 2");
   end

   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_q;
   logic             int_q;
   logic             int_rise;
   logic             int_fall;

   assign reload = {div_val, {SCALE_SH{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         int_q <= 1'b0;
      end else if (!active) begin
         cnt_q <= reload;
         int_q <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q <= reload;
         int_q <= ~int_q;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign int_rise = active && (cnt_q == '0) && !int_q;
   assign int_fall = active && (cnt_q == '0) && int_q;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q;
   logic                   ext_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         ext_prev_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
         ext_prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_lvl = sync_q[SYNC_STAGES-1];

   always_comb begin
      if (ext_mode) begin
         clk_lvl = ext_lvl;
         rise_p  = ext_lvl && !ext_prev_q;
         fall_p  = !ext_lvl && ext_prev_q;
      end else begin
         clk_lvl = int_q;
         rise_p  = int_rise;
         fall_p  = int_fall;
      end
   end

   // R1: divider clock rests low while idle
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !int_q);

   // R1: no toggle until the half-period count runs out
   a_r1_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_q != '0) |=> $stable(int_q));

   // R10: rising and falling pulses are exclusive
   a_r10_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_p, fall_p}));

endmodule

// File: rtl/sio_frame_ctl.sv
module sio_frame_ctl
   import sio_pkg::*;
#(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             ext_mode,
   input  logic             bidir_mode,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             rise_p,
   input  logic             fall_p,
   output logic             active,
   output logic             end_lvl,
   output logic             shift_edge,
   output logic             sample_valid
);

   if (LEN_W < 2) begin : g_bad_len
      $error("sio_frame_ctl: LEN_W must be at least 2");
   end

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

   sio_state_e       state_q;
   logic [LEN_W-1:0] bit_q;
   logic [LEN_W-1:0] eff_len;
   logic [LEN_W-1:0] last_idx;
   logic             start_ok;

   always_comb begin
      if (bidir_mode && frame_len < LEN_TWO) begin
         eff_len = LEN_TWO;
      end else if (frame_len == '0) begin
         eff_len = LEN_ONE;
      end else begin
         eff_len = frame_len;
      end
   end

   assign last_idx = eff_len - LEN_ONE;
   assign start_ok = run_en && (!ext_mode || fall_p);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_SHIFT;
                  bit_q   <= '0;
               end
            end
            ST_SHIFT: begin
               if (fall_p) begin
                  if (bit_q == last_idx) begin
                     state_q <= ST_END;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            ST_END: begin
               if (fall_p) begin
                  bit_q <= '0;
                  if (run_en) begin
                     state_q <= ST_SHIFT;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign active       = (state_q != ST_IDLE);
   assign end_lvl      = (state_q == ST_END);
   assign shift_edge   = (state_q == ST_SHIFT) && fall_p;
   assign sample_valid = (state_q == ST_SHIFT) && rise_p && (bit_q != '0);

   // R3: idle holds while run is low
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !run_en) |=> (state_q == ST_IDLE));

   // R5: a frame in progress ignores the run bit until its last falling edge
   a_r5_shift_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT && !fall_p) |=> (state_q == ST_SHIFT));

   // R4: end strobe lasts until the next falling edge
   a_r4_end_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_END && !fall_p) |=> (state_q == ST_END));

   // R7: bit index never passes the effective length
   a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT) |-> (bit_q < eff_len));

   // R6: no sample is taken in the frame's first cycle
   a_r6_first_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_SHIFT) |-> !sample_valid);

endmodule

// File: rtl/sio_pad.sv
module sio_pad (
   input  logic level,
   input  logic od_mode,
   input  logic release_i,
   output logic pin_o,
   output logic pin_oe
);

   always_comb begin
      if (release_i) begin
         pin_o  = 1'b0;
         pin_oe = 1'b0;
      end else if (od_mode) begin
         pin_o  = 1'b0;
         pin_oe = !level;
      end else begin
         pin_o  = level;
         pin_oe = 1'b1;
      end
   end

endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
   import sio_pkg::*;
#(
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned LEN_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_DIV     = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             bidir_mode,
   input  logic             od_mode,
   input  logic             ext_clk_mode,
   input  logic             sclk_i,
   output logic             sclk_o,
   output logic             sclk_oe,
   output logic             send_o,
   output logic             send_oe,
   output logic             shift_edge,
   output logic             sample_valid,
   output logic             too_fast
);

   if (MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
      $error("sio_clkgen: MIN_DIV does not fit in DIV_W bits");
   end

   localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

   logic clk_lvl;
   logic rise_p;
   logic fall_p;
   logic ctl_active;
   logic end_lvl;

   sio_div #(
      .DIV_W       (DIV_W),
      .SCALE_SH    (SIO_SCALE_SH),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (ctl_active && !ext_clk_mode),
      .ext_mode  (ext_clk_mode),
      .div_val   (clk_div),
      .ext_clk_i (sclk_i),
      .clk_lvl   (clk_lvl),
      .rise_p    (rise_p),
      .fall_p    (fall_p)
   );

   sio_frame_ctl #(
      .LEN_W (LEN_W)
   ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .ext_mode     (ext_clk_mode),
      .bidir_mode   (bidir_mode),
      .frame_len    (frame_len),
      .rise_p       (rise_p),
      .fall_p       (fall_p),
      .active       (ctl_active),
      .end_lvl      (end_lvl),
      .shift_edge   (shift_edge),
      .sample_valid (sample_valid)
   );

   logic [SIO_PIN_CNT-1:0] pin_lvl;
   logic [SIO_PIN_CNT-1:0] pin_rel;
   logic [SIO_PIN_CNT-1:0] pin_out;
   logic [SIO_PIN_CNT-1:0] pin_en;

   assign pin_lvl = {end_lvl, clk_lvl};
   assign pin_rel = {1'b0, ext_clk_mode};

   for (genvar p = 0; p < SIO_PIN_CNT; p++) begin : g_pad
      sio_pad u_pad (
         .level     (pin_lvl[p]),
         .od_mode   (od_mode),
         .release_i (pin_rel[p]),
         .pin_o     (pin_out[p]),
         .pin_oe    (pin_en[p])
      );
   end

   assign sclk_o  = pin_out[0];
   assign sclk_oe = pin_en[0];
   assign send_o  = pin_out[1];
   assign send_oe = pin_en[1];

   assign too_fast = !ext_clk_mode && (clk_div < MIN_DIV_V);

   // R8: open-drain end pin releases while the strobe is high
   a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
      (od_mode && end_lvl) |-> !send_oe);

   // R9: clock pin never driven in external-clock mode
   a_r9_ext_input: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk_mode |-> !sclk_oe);

   // R10: no advance and sample in the same cycle
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_edge && sample_valid));

endmodule

// File: tb/tb_sio_clkgen.sv
module tb_sio_clkgen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [14:0] clk_div = 15'd1;
   logic [7:0]  frame_len = 8'd4;
   logic        bidir_mode = 1'b0;
   logic        od_mode = 1'b0;
   logic        ext_clk_mode = 1'b0;
   logic        ext_clk = 1'b0;
   logic        sclk_o, sclk_oe, send_o, send_oe;
   logic        shift_edge, sample_valid, too_fast;

   always #10 clk = ~clk;

   sio_clkgen dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .clk_div      (clk_div),
      .frame_len    (frame_len),
      .bidir_mode   (bidir_mode),
      .od_mode      (od_mode),
      .ext_clk_mode (ext_clk_mode),
      .sclk_i       (ext_clk),
      .sclk_o       (sclk_o),
      .sclk_oe      (sclk_oe),
      .send_o       (send_o),
      .send_oe      (send_oe),
      .shift_edge   (shift_edge),
      .sample_valid (sample_valid),
      .too_fast     (too_fast)
   );

   typedef struct {
      int shifts;
      int samples;
      int end_len;
   } frame_t;

   frame_t expq[$];
   int  total = 0;
   int  bad = 0;
   int  toggles = 0;
   int  exp_half = 9;
   bit  chk_half = 1'b0;
   bit  ext_run = 1'b0;
   logic clk_res, end_res;

   always_comb begin
      clk_res = sclk_oe ? sclk_o : (ext_clk_mode ? ext_clk : 1'b1);
      end_res = send_oe ? send_o : 1'b1;
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push_frame(int len, int samples, int end_len);
      frame_t f;
      f.shifts  = len;
      f.samples = samples;
      f.end_len = end_len;
      expq.push_back(f);
   endtask

   // external clock: period of ten reference cycles
   initial begin
      int ec = 0;
      forever begin
         @(negedge clk);
         if (ext_run) begin
            ec++;
            if (ec == 5) begin
               ext_clk = ~ext_clk;
               ec = 0;
            end
         end
      end
   end

   // monitor: pops the expected frame shape when each end strobe falls
   initial begin
      int n_sh = 0, n_sa = 0, cap_sh = 0, cap_sa = 0, e_len = 0, hi_len = 0;
      logic prev_end = 1'b0, prev_clk = 1'b0;
      frame_t f;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (shift_edge) n_sh++;
            if (sample_valid) n_sa++;
            if (clk_res !== prev_clk) toggles++;
            if (chk_half) begin
               if (clk_res) hi_len++;
               if (prev_clk && !clk_res) begin
                  check(hi_len == exp_half, "R1", "half period", hi_len, exp_half);
                  hi_len = 0;
               end
            end else begin
               hi_len = 0;
            end
            if (end_res && !prev_end) begin
               cap_sh = n_sh; cap_sa = n_sa; n_sh = 0; n_sa = 0; e_len = 0;
            end
            if (end_res) e_len++;
            if (!end_res && prev_end) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R4", "unexpected frame", 1, 0);
               end else begin
                  f = expq.pop_front();
                  check(cap_sh == f.shifts, "R4", "shift edges per frame", cap_sh, f.shifts);
                  check(cap_sa == f.samples, "R6", "samples per frame", cap_sa, f.samples);
                  check(e_len == f.end_len, "R4", "end strobe length", e_len, f.end_len);
               end
            end
            prev_end = end_res;
            prev_clk = clk_res;
         end
      end
   end

   task automatic run_frames(int n);
      run_en = 1'b1;
      repeat (n) @(posedge end_res);
      @(negedge clk);
      run_en = 1'b0;
      @(negedge end_res);
      repeat (5) @(negedge clk);
      check(expq.size() == 0, "R4", "frames left in queue", expq.size(), 0);
   endtask

   task automatic tests();
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: reset state
      check(sclk_o == 1'b0 && sclk_oe == 1'b1, "R3", "clock pin after reset", sclk_o, 0);
      check(send_o == 1'b0, "R3", "end pin after reset", send_o, 0);
      // R2: speed flag
      check(too_fast == 1'b1, "R2", "flag div=1", too_fast, 1);
      clk_div = 15'd23; @(negedge clk);
      check(too_fast == 1'b1, "R2", "flag div=23", too_fast, 1);
      clk_div = 15'd24; @(negedge clk);
      check(too_fast == 1'b0, "R2", "flag div=24", too_fast, 0);
      clk_div = 15'd23; ext_clk_mode = 1'b1; @(negedge clk);
      check(too_fast == 1'b0, "R2", "flag ext mode", too_fast, 0);
      ext_clk_mode = 1'b0; clk_div = 15'd1;
      // R3: idle with run low
      repeat (100) @(negedge clk);
      check(toggles == 0, "R3", "toggles while idle", toggles, 0);
      // R4 R6 R1: two back-to-back frames, L=4, H=9
      chk_half = 1'b1; exp_half = 9; frame_len = 8'd4;
      push_frame(4, 3, 18); push_frame(4, 3, 18);
      run_frames(2);
      // R5: clear run mid-frame, L=5, H=17
      clk_div = 15'd2; exp_half = 17; frame_len = 8'd5;
      push_frame(5, 4, 34);
      run_en = 1'b1;
      repeat (2) @(posedge shift_edge);
      @(negedge clk);
      run_en = 1'b0;
      @(negedge end_res);
      repeat (20) @(negedge clk);
      check(expq.size() == 0, "R5", "frame completed", expq.size(), 0);
      t0 = toggles;
      repeat (200) @(negedge clk);
      check(toggles == t0, "R5", "clock stopped after frame", toggles - t0, 0);
      // R7: length clamping
      clk_div = 15'd1; exp_half = 9;
      bidir_mode = 1'b1; frame_len = 8'd1;
      push_frame(2, 1, 18); run_frames(1);
      bidir_mode = 1'b0; frame_len = 8'd1;
      push_frame(1, 0, 18); run_frames(1);
      frame_len = 8'd0;
      push_frame(1, 0, 18); run_frames(1);
      // R8: open drain
      od_mode = 1'b1; frame_len = 8'd3; @(negedge clk);
      check(sclk_o == 1'b0 && sclk_oe == 1'b1, "R8", "od clock pulls low at rest", sclk_oe, 1);
      check(send_oe == 1'b1, "R8", "od end pulls low at rest", send_oe, 1);
      push_frame(3, 2, 18);
      run_en = 1'b1;
      @(posedge end_res); @(negedge clk);
      check(send_oe == 1'b0 && send_o == 1'b0, "R8", "od end released in strobe", send_oe, 0);
      run_en = 1'b0;
      @(negedge end_res);
      repeat (5) @(negedge clk);
      check(expq.size() == 0, "R8", "od frame done", expq.size(), 0);
      od_mode = 1'b0; @(negedge clk);
      check(send_oe == 1'b1, "R8", "push-pull end enable", send_oe, 1);
      // R9: external clock
      chk_half = 1'b0; ext_run = 1'b1; ext_clk_mode = 1'b1;
      repeat (30) @(negedge clk);
      check(sclk_oe == 1'b0, "R9", "clock pin released", sclk_oe, 0);
      push_frame(3, 2, 10); run_frames(1);
      ext_clk_mode = 1'b0; ext_run = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      fork
         tests();
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "R4", "watchdog expired", 1, 0);
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule